// File: doc/BRIEF.md
# Drive Power-Mode and Standby Timer Controller

This block keeps track of which power state a disk drive is in (active, idle, standby or sleep) and sequences the head unload that entering standby or sleep requires. It receives already-decoded power commands together with the sector count that came with them. It also receives a pulse for host activity, a prescaled time tick, and separate hard and soft reset strobes. It drives the current mode and a head-unload request. When the mechanics report that the unload has finished, it returns a one-cycle completion strobe.

An inactivity timer moves the drive from active or idle into standby by itself when no command arrives in time. Only the two commands that carry a timer value (standby with count, idle with count) can program that timer. The period comes from an 8-bit code. Sleep shuts everything down, and only a reset brings the drive back from it. While an unload ordered by a command or a reset is in progress, a busy flag stays high.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After the asynchronous power-on reset, the outputs are mode 0 (active), unloadReq 0, busy 0 and parkDone 0. The timer is disabled, so no number of ticks raises unloadReq.
- R2: Command codes on cmdOp are: 1 standby with count, 2 standby now, 3 idle with count, 4 idle now, 5 sleep, 6 media access, 0 and 7 other. Mode codes are: 0 active, 1 idle, 2 standby, 3 sleep. When the heads are loaded, codes 3 and 4 give mode 1 one cycle after the command, code 6 gives mode 0, and codes 0 and 7 leave the mode unchanged.
- R3: Codes 1, 2 and 5 issued in mode 0 or 1 raise unloadReq and busy in the next cycle and leave the mode unchanged. The cycle after unloadDone is sampled, unloadReq and busy are low, the mode equals the target (2 or 3), and parkDone is high for exactly one cycle.
- R4: Codes 1, 2 or 5 issued in standby need no unload. The next cycle shows the target mode and a parkDone pulse, with unloadReq low.
- R5: The timer code v selects a period in units of TICKS_PER_UNIT ticks: 0 disables the timer, 1 to 240 gives v units, 241 to 251 gives (v−240)×360 units, and 252 to 255 gives MAX_UNITS units.
- R6: Only codes 1 and 3 load the timer from cmdCount; codes 2 and 4 keep the previous setting. In mode 0 or 1, the tick that completes the period raises unloadReq in the next cycle with busy low, and the target is standby.
- R7: Every accepted command and every hostAct pulse restarts the inactivity count from zero.
- R8: Standby still accepts commands, and the timer does not count while in standby. Code 6 in standby returns the mode to 0.
- R9: In sleep every command is ignored. A hard or soft reset moves the drive from sleep or standby to mode 0 in the next cycle, without an unload.
- R10: A hard or soft reset with the heads loaded raises unloadReq and busy. After unloadDone the mode is 0. A hard reset disables the timer; a soft reset keeps its setting.
- R11: Commands that arrive while an unload is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| hardRst | input | 1 | Hardware reset strobe |
| softRst | input | 1 | Software reset strobe |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 3 | Decoded command code |
| cmdCount | input | 8 | Sector count that came with the command (timer code) |
| hostAct | input | 1 | Host activity pulse |
| tick | input | 1 | Prescaled time tick |
| unloadDone | input | 1 | Heads have finished unloading |
| mode | output | 2 | Current power mode |
| unloadReq | output | 1 | Head unload request, held until unloadDone |
| busy | output | 1 | Unload ordered by a command or a reset is pending |
| parkDone | output | 1 | One-cycle completion strobe for a standby or sleep entry |

## Verification
A wrong timer state shows as an unload request one tick too early or one tick too late. For that reason the bench checks the cycle just before the expected expiry and the cycle of the expiry itself, for each band of the timer code. A wrong mode or pending-unload state shows in the cycle after the command: the unload request appears when it should not, a parkDone pulse is missing, or sleep is left without a reset. Each of these is compared in the very next cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_SLEEP   = 2'd3
  } mode_t;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_STANDBY     = 3'd1,
    OP_STANDBY_NOW = 3'd2,
    OP_IDLE        = 3'd3,
    OP_IDLE_NOW    = 3'd4,
    OP_SLEEP       = 3'd5,
    OP_MEDIA       = 3'd6,
    OP_OTHER       = 3'd7
  } op_t;

  // Strobes from the control FSM to the timer datapath.
  typedef struct packed {
    logic clear;   // forget the programmed period
    logic load;    // take a new period from the command's count
    logic reload;  // restart the inactivity count
    logic run;     // heads loaded: ticks advance the count
  } tmrCtl_t;

  localparam logic [7:0] SHORT_TOP = 8'd240;  // last code in 1-unit steps
  localparam logic [7:0] LONG_TOP  = 8'd251;  // last code in long steps
  localparam int         LONG_UNITS = 360;    // units per long step

endpackage

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer
  import pwr_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 5,
  parameter int MAX_UNITS      = 4320
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  tmrCtl_t    ctl,
  input  logic [7:0] code,
  output logic       expire
);

  localparam int MAX_TICKS = MAX_UNITS * TICKS_PER_UNIT;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] countQ;
  logic             armed;

  function automatic logic [CNT_W-1:0] periodOf(input logic [7:0] v);
    int units;
    if (v == 8'd0)            units = 0;
    else if (v <= SHORT_TOP)  units = int'(v);
    else if (v <= LONG_TOP)   units = (int'(v) - int'(SHORT_TOP)) * LONG_UNITS;
    else                      units = MAX_UNITS;
    return CNT_W'(units * TICKS_PER_UNIT);
  endfunction

  assign armed  = (periodQ != '0);
  assign expire = ctl.run && tick && armed && !ctl.reload && !ctl.load &&
                  !ctl.clear && (countQ == periodQ - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '0;
      countQ  <= '0;
    end else if (ctl.clear) begin
      periodQ <= '0;
      countQ  <= '0;
    end else if (ctl.load) begin
      periodQ <= periodOf(code);
      countQ  <= '0;
    end else if (ctl.reload) begin
      countQ  <= '0;
    end else if (ctl.run && tick && armed) begin
      countQ  <= expire ? '0 : countQ + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hardRst,
  input  logic    softRst,
  input  logic    cmdValid,
  input  op_t     cmdOp,
  input  logic    hostAct,
  input  logic    unloadDone,
  input  logic    expire,
  output tmrCtl_t tmrCtl,
  output mode_t   mode,
  output logic    parking,
  output logic    busy,
  output logic    parkDone
);

  mode_t modeQ, modeN, tgtQ, tgtN;
  logic  parkQ, parkN, busyQ, busyN, doneQ, doneN;
  logic  anyRst, loaded, accept, wantStandby;

  assign anyRst = hardRst || softRst;
  assign loaded = (modeQ == MODE_ACTIVE) || (modeQ == MODE_IDLE);
  assign accept = cmdValid && !parkQ && (modeQ != MODE_SLEEP) && !anyRst;
  assign wantStandby = (cmdOp == OP_STANDBY) || (cmdOp == OP_STANDBY_NOW);

  // Timer strobes depend only on inputs and state, never on expire.
  always_comb begin
    tmrCtl        = '0;
    tmrCtl.clear  = hardRst;
    tmrCtl.load   = accept && ((cmdOp == OP_STANDBY) || (cmdOp == OP_IDLE));
    tmrCtl.reload = accept || hostAct ||
                    (anyRst && !parkQ && !loaded) ||
                    (parkQ && unloadDone && (anyRst || tgtQ == MODE_ACTIVE));
    tmrCtl.run    = loaded && !parkQ;
  end

  always_comb begin
    modeN = modeQ;
    tgtN  = tgtQ;
    parkN = parkQ;
    busyN = busyQ;
    doneN = 1'b0;
    if (anyRst) begin
      if (parkQ && unloadDone) begin
        parkN = 1'b0;
        busyN = 1'b0;
        doneN = 1'b1;
        modeN = MODE_ACTIVE;
      end else if (parkQ || loaded) begin
        parkN = 1'b1;
        busyN = 1'b1;
        tgtN  = MODE_ACTIVE;
      end else begin
        modeN = MODE_ACTIVE;
      end
    end else if (parkQ) begin
      if (unloadDone) begin
        parkN = 1'b0;
        busyN = 1'b0;
        doneN = 1'b1;
        modeN = tgtQ;
      end
    end else if (accept) begin
      if (wantStandby || cmdOp == OP_SLEEP) begin
        if (loaded) begin
          parkN = 1'b1;
          busyN = 1'b1;
          tgtN  = wantStandby ? MODE_STANDBY : MODE_SLEEP;
        end else begin
          doneN = 1'b1;
          modeN = wantStandby ? MODE_STANDBY : MODE_SLEEP;
        end
      end else if (cmdOp == OP_IDLE || cmdOp == OP_IDLE_NOW) begin
        modeN = MODE_IDLE;
      end else if (cmdOp == OP_MEDIA) begin
        modeN = MODE_ACTIVE;
      end
    end else if (expire) begin
      parkN = 1'b1;
      tgtN  = MODE_STANDBY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_ACTIVE;
      tgtQ  <= MODE_ACTIVE;
      parkQ <= 1'b0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      modeQ <= modeN;
      tgtQ  <= tgtN;
      parkQ <= parkN;
      busyQ <= busyN;
      doneQ <= doneN;
    end
  end

  assign mode     = modeQ;
  assign parking  = parkQ;
  assign busy     = busyQ;
  assign parkDone = doneQ;

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 5,
  parameter int MAX_UNITS      = 4320
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hardRst,
  input  logic       softRst,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdCount,
  input  logic       hostAct,
  input  logic       tick,
  input  logic       unloadDone,
  output logic [1:0] mode,
  output logic       unloadReq,
  output logic       busy,
  output logic       parkDone
);

  tmrCtl_t tmrCtl;
  logic    expire;
  mode_t   modeS;

  pwr_mode_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .hardRst   (hardRst),
    .softRst   (softRst),
    .cmdValid  (cmdValid),
    .cmdOp     (op_t'(cmdOp)),
    .hostAct   (hostAct),
    .unloadDone(unloadDone),
    .expire    (expire),
    .tmrCtl    (tmrCtl),
    .mode      (modeS),
    .parking   (unloadReq),
    .busy      (busy),
    .parkDone  (parkDone)
  );

  pwr_idle_timer #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .MAX_UNITS     (MAX_UNITS)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .ctl   (tmrCtl),
    .code  (cmdCount),
    .expire(expire)
  );

  assign mode = modeS;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hardRst,
  input logic       softRst,
  input logic       unloadDone,
  input logic [1:0] mode,
  input logic       unloadReq,
  input logic       busy,
  input logic       parkDone
);

  // R3: an acknowledged unload drops the request
  p_req_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    unloadReq && unloadDone |=> !unloadReq);

  // R3: busy only while an unload is pending
  p_busy_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> unloadReq);

  // R3: every finished unload reports completion
  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unloadReq) |-> parkDone);

  // R3: an unload starts only with heads loaded
  p_rise_loaded_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unloadReq) |-> (mode == 2'd0 || mode == 2'd1));

  // R11: mode frozen while an unload is outstanding
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    unloadReq && !unloadDone |=> $stable(mode));

  // R9: sleep is left only through a reset
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd3 && !hardRst && !softRst |=> mode == 2'd3);

  // R9: reset wakes a parked drive at once
  p_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hardRst || softRst) && !unloadReq && (mode == 2'd2 || mode == 2'd3)
    |=> mode == 2'd0);

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hardRst   (hardRst),
  .softRst   (softRst),
  .unloadDone(unloadDone),
  .mode      (mode),
  .unloadReq (unloadReq),
  .busy      (busy),
  .parkDone  (parkDone)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;

  localparam int TPU = 5;
  localparam int MAXU = 4320;

  logic clk = 1'b0;
  logic rstN, hardRst, softRst, cmdValid, hostAct, tick, unloadDone;
  logic [2:0] cmdOp;
  logic [7:0] cmdCount;
  logic [1:0] mode;
  logic unloadReq, busy, parkDone;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [4:0] expQ[$];
  string      tagQ[$];
  logic [4:0] eItem, gItem;
  string      eTag;

  always #10 clk = ~clk;

  pwr_mode_ctl u_dut (
    .clk(clk), .rstN(rstN), .hardRst(hardRst), .softRst(softRst),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdCount(cmdCount),
    .hostAct(hostAct), .tick(tick), .unloadDone(unloadDone),
    .mode(mode), .unloadReq(unloadReq), .busy(busy), .parkDone(parkDone)
  );

  // monitor: compares the next expected item at each falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      eItem = expQ.pop_front();
      eTag  = tagQ.pop_front();
      gItem = {mode, unloadReq, busy, parkDone};
      tests++;
      if (gItem !== eItem) begin
        fails++;
        $display("FAIL %s: got mode=%0d req=%0b busy=%0b done=%0b, expected mode=%0d req=%0b busy=%0b done=%0b",
                 eTag, gItem[4:3], gItem[2], gItem[1], gItem[0],
                 eItem[4:3], eItem[2], eItem[1], eItem[0]);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(logic [1:0] m, logic r, logic b, logic d, string tag);
    expQ.push_back({m, r, b, d});
    tagQ.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] cnt);
    cmdValid = 1'b1; cmdOp = op; cmdCount = cnt;
    cyc();
    cmdValid = 1'b0; cmdOp = 3'd0; cmdCount = 8'd0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) cyc();
      tick = 1'b0;
    end
  endtask

  task automatic ackUnload();
    unloadDone = 1'b1; cyc(); unloadDone = 1'b0;
  endtask

  function automatic int periodTicks(int v);
    if (v == 0) return 0;
    if (v <= 240) return v * TPU;
    if (v <= 251) return (v - 240) * 360 * TPU;
    return MAXU * TPU;
  endfunction

  task automatic timerCase(int v, string tag);
    int p = periodTicks(v);
    issue(3'd3, 8'(v));          chk(2'd1, 0, 0, 0, tag);
    ticks(p - 1);                chk(2'd1, 0, 0, 0, tag);
    ticks(1);                    chk(2'd1, 1, 0, 0, tag);
    ackUnload();                 chk(2'd2, 0, 0, 1, tag);
    issue(3'd6, 8'd0);           chk(2'd0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (R1-related run): run still going, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hardRst = 0; softRst = 0; cmdValid = 0; hostAct = 0;
    tick = 0; unloadDone = 0; cmdOp = 3'd0; cmdCount = 8'd0;
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    chk(2'd0, 0, 0, 0, "R1 reset state");
    ticks(50);                     chk(2'd0, 0, 0, 0, "R1 timer disabled");

    issue(3'd4, 8'd0);             chk(2'd1, 0, 0, 0, "R2 idle now");
    issue(3'd6, 8'd0);             chk(2'd0, 0, 0, 0, "R2 media");
    issue(3'd7, 8'd0);             chk(2'd0, 0, 0, 0, "R2 other");
    issue(3'd0, 8'd0);             chk(2'd0, 0, 0, 0, "R2 code zero");

    // idle with count 2 -> 10 ticks
    issue(3'd3, 8'd2);             chk(2'd1, 0, 0, 0, "R6 idle arms");
    ticks(9);                      chk(2'd1, 0, 0, 0, "R5 one before period");
    ticks(1);                      chk(2'd1, 1, 0, 0, "R6 expiry unload");
    ackUnload();                   chk(2'd2, 0, 0, 1, "R6 standby reached");
    cyc();                         chk(2'd2, 0, 0, 0, "R3 done one cycle");

    ticks(30);                     chk(2'd2, 0, 0, 0, "R8 no count in standby");
    issue(3'd6, 8'd0);             chk(2'd0, 0, 0, 0, "R8 media wakes");
    ticks(7);
    hostAct = 1'b1; cyc(); hostAct = 1'b0;
    ticks(9);                      chk(2'd0, 0, 0, 0, "R7 activity reload");
    ticks(1);                      chk(2'd0, 1, 0, 0, "R7 expiry after reload");
    ackUnload();                   chk(2'd2, 0, 0, 1, "R7 standby");

    issue(3'd2, 8'd0);             chk(2'd2, 0, 0, 1, "R4 standby now parked");
    issue(3'd5, 8'd0);             chk(2'd3, 0, 0, 1, "R4 sleep parked");

    issue(3'd6, 8'd0);             chk(2'd3, 0, 0, 0, "R9 media ignored");
    issue(3'd3, 8'd1);             chk(2'd3, 0, 0, 0, "R9 idle ignored");
    softRst = 1'b1; cyc(); softRst = 1'b0;
    chk(2'd0, 0, 0, 0, "R9 soft reset wakes");
    ticks(9);                      chk(2'd0, 0, 0, 0, "R10 soft keeps period");
    ticks(1);                      chk(2'd0, 1, 0, 0, "R10 soft keeps period");
    ackUnload();                   chk(2'd2, 0, 0, 1, "R10 standby");

    issue(3'd6, 8'd0);             chk(2'd0, 0, 0, 0, "R2 media");
    issue(3'd1, 8'd0);             chk(2'd0, 1, 1, 0, "R3 standby unload");
    issue(3'd6, 8'd0);             chk(2'd0, 1, 1, 0, "R11 cmd ignored");
    ackUnload();                   chk(2'd2, 0, 0, 1, "R3 standby done");
    issue(3'd6, 8'd0);             chk(2'd0, 0, 0, 0, "R8 media wakes");
    ticks(100);                    chk(2'd0, 0, 0, 0, "R5 code zero disables");

    issue(3'd3, 8'd1);             chk(2'd1, 0, 0, 0, "R6 idle arms");
    issue(3'd4, 8'd0);             chk(2'd1, 0, 0, 0, "R6 idle now");
    ticks(4);                      chk(2'd1, 0, 0, 0, "R6 kept period");
    ticks(1);                      chk(2'd1, 1, 0, 0, "R6 kept period");
    ackUnload();                   chk(2'd2, 0, 0, 1, "R6 standby");

    issue(3'd6, 8'd0);             chk(2'd0, 0, 0, 0, "R2 media");
    issue(3'd5, 8'd0);             chk(2'd0, 1, 1, 0, "R3 sleep unload");
    ackUnload();                   chk(2'd3, 0, 0, 1, "R3 sleep done");
    hardRst = 1'b1; cyc(); hardRst = 1'b0;
    chk(2'd0, 0, 0, 0, "R9 hard reset wakes");
    ticks(20);                     chk(2'd0, 0, 0, 0, "R10 hard clears timer");

    issue(3'd3, 8'd1);             chk(2'd1, 0, 0, 0, "R6 idle arms");
    hardRst = 1'b1; cyc(); hardRst = 1'b0;
    chk(2'd1, 1, 1, 0, "R10 reset unload");
    ackUnload();                   chk(2'd0, 0, 0, 1, "R10 back to active");
    ticks(10);                     chk(2'd0, 0, 0, 0, "R10 hard clears timer");

    timerCase(240, "R5 short band top");
    timerCase(241, "R5 long band bottom");
    timerCase(251, "R5 long band top");
    timerCase(255, "R5 fixed maximum");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule